// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a 4-bit synchronous up-counter with a parallel preset and a carry-style chaining flag. Each rising clock edge performs one of four operations. In order of precedence they are clear, load, count-up and hold. Clear, load and count-up each depend on their own control, and hold applies when none of the three is active. The count runs through a modulo-16 binary sequence and returns from 15 to 0.

There are two count enables. Both must be high for the counter to advance. Only one of them, the chaining enable, also qualifies the terminal-count flag. A wide counter is built from several stages. The first stage's terminal-count output feeds the chaining enable of the next stage, and so on down the chain. The shared count enable then gates the whole chain without changing the carry path.

A build-time parameter selects how the clear behaves. In one variant it acts on the flip-flops at once, without a clock. In the other it waits for the next rising edge.

The per-edge operation is an enumerated mode chosen each cycle. The mode names and the conditions that select each one are listed below.

| Mode | Selected when | Next count |
|---|---|---|
| MODE_CLEAR | clear_n low | 0 |
| MODE_LOAD | clear_n high and load_n low | din |
| MODE_COUNT | clear_n and load_n high, cnt_en and chain_en high | count + 1, modulo 16 |
| MODE_HOLD | any other case | count |

Top module: `presettable_counter`

## Requirements
- R1: With mode MODE_COUNT selected at a rising edge and a count of 15, the count becomes 0 after that edge.
- R2: When clear_n, load_n, cnt_en and chain_en are all high at a rising edge, the count increases by exactly 1 after that edge.
- R3: When clear_n and load_n are high and either cnt_en or chain_en is low at a rising edge, the count keeps its value.
- R4: When clear_n is high and load_n is low at a rising edge, the count takes din after that edge. This holds whatever the enables are, and the loaded value is not incremented in that same cycle.
- R5: With CLEAR_SYNC=1, a low clear_n changes nothing until the next rising edge. At that edge the count becomes 0, and the clear takes priority over both load and count.
- R6: With CLEAR_SYNC=0, a low clear_n forces the count to 0 at once, with no clock edge needed, and the count stays 0 while clear_n is low.
- R7: term_cnt is high exactly when chain_en is high and the count is 15. It follows chain_en combinationally within the same cycle, and cnt_en has no effect on it.
- R8: Three stages chained through term_cnt into the next stage's chain_en form a 12-bit counter that goes from 4094 to 4095, then to 0, then to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear; asynchronous or synchronous depending on CLEAR_SYNC |
| load_n | input | 1 | Active-low parallel preset of din |
| cnt_en | input | 1 | Count enable that does not affect term_cnt |
| chain_en | input | 1 | Count enable that also qualifies term_cnt; used for chaining |
| din | input | WIDTH | Parallel preset value |
| count | output | WIDTH | Current count |
| term_cnt | output | 1 | High when chain_en is high and count is all ones |

## Verification
The bench builds two single stages with the same stimulus. One uses CLEAR_SYNC=0 and the other uses CLEAR_SYNC=1. Dropping clear_n in the middle of a cycle therefore shows the difference between the variants directly: the asynchronous stage is already zero while the synchronous stage still holds its old value. The bench also builds three CLEAR_SYNC=0 stages with the default WIDTH=4, chained through term_cnt. This chain brings the 12-bit rollover and the same-cycle carry path within reach.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
    import cnt_pkg::*;
(
    input  logic      clear_n,
    input  logic      load_n,
    input  logic      cnt_en,
    input  logic      chain_en,
    output cnt_mode_e mode
);
    // Fixed precedence: clear, then load, then count, then hold
    always_comb begin
        if (!clear_n)
            mode = MODE_CLEAR;
        else if (!load_n)
            mode = MODE_LOAD;
        else if (cnt_en && chain_en)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter bit CLEAR_SYNC = 1'b0
) (
    input  logic             clk,
    input  logic             clear_n,
    input  cnt_mode_e        mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;

    // Next-state selection for every mode
    always_comb begin
        unique case (mode)
            MODE_CLEAR: count_d = '0;
            MODE_LOAD:  count_d = din;
            MODE_COUNT: count_d = count_q + STEP;
            MODE_HOLD:  count_d = count_q;
            default:    count_d = count_q;
        endcase
    end

    generate
        if (CLEAR_SYNC) begin : g_sync_clear
            always_ff @(posedge clk) begin
                count_q <= count_d;
            end
        end else begin : g_async_clear
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n)
                    count_q <= '0;
                else
                    count_q <= count_d;
            end
        end
    endgenerate

    assign count = count_q;
endmodule

// File: rtl/cnt_term_detect.sv
module cnt_term_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             chain_en,
    output logic             term_cnt
);
    localparam logic [WIDTH-1:0] LAST = {WIDTH{1'b1}};

    always_comb begin
        term_cnt = chain_en && (count == LAST);
    end
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter bit CLEAR_SYNC = 1'b0
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             term_cnt
);
    cnt_mode_e mode;

    cnt_mode_sel u_mode (
        .clear_n  (clear_n),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .mode     (mode)
    );

    cnt_state_reg #(
        .WIDTH      (WIDTH),
        .CLEAR_SYNC (CLEAR_SYNC)
    ) u_reg (
        .clk     (clk),
        .clear_n (clear_n),
        .mode    (mode),
        .din     (din),
        .count   (count)
    );

    cnt_term_detect #(
        .WIDTH (WIDTH)
    ) u_tc (
        .count    (count),
        .chain_en (chain_en),
        .term_cnt (term_cnt)
    );
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
    parameter int WIDTH      = 4,
    parameter bit CLEAR_SYNC = 1'b0
) (
    input logic             clk,
    input logic             clear_n,
    input logic             load_n,
    input logic             cnt_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count,
    input logic             term_cnt
);
    localparam logic [WIDTH-1:0] LAST = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic prev_clear_n = 1'b1;
    logic armed        = 1'b0;

    always_ff @(posedge clk) begin
        prev_clear_n <= clear_n;
        armed        <= 1'b1;
    end

    // R5 / R6: an edge that saw clear low leaves the count at zero
    always_ff @(posedge clk) begin
        if (!prev_clear_n)
            assert_clear_zero_R5: assert (count == '0)
                else $error("clear did not zero count");
        if (!CLEAR_SYNC && armed && !clear_n)
            assert_async_zero_R6: assert (count == '0)
                else $error("async clear not holding zero");
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cnt_en && chain_en && count == LAST) |=> (count == '0));

    assert_inc_R2: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cnt_en && chain_en) |=> (count == $past(count) + STEP));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(cnt_en && chain_en)) |=> $stable(count));

    assert_load_R4: assert property (@(posedge clk) disable iff (!clear_n)
        (!load_n) |=> (count == $past(din)));

    assert_tc_low_R7: assert property (@(posedge clk) disable iff (!clear_n)
        (!chain_en) |-> !term_cnt);

    assert_tc_high_R7: assert property (@(posedge clk) disable iff (!clear_n)
        (chain_en && count == LAST) |-> term_cnt);
endmodule

bind presettable_counter cnt_checker #(
    .WIDTH      (WIDTH),
    .CLEAR_SYNC (CLEAR_SYNC)
) u_chk (
    .clk      (clk),
    .clear_n  (clear_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .din      (din),
    .count    (count),
    .term_cnt (term_cnt)
);

// File: tb/tb_presettable_counter.sv
module tb_presettable_counter;
    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic       load_n = 1'b0;
    logic       cnt_en = 1'b1;
    logic       chain_en = 1'b1;
    logic [3:0] din = 4'hA;
    logic [3:0] cnt_a, cnt_s;
    logic       tc_a, tc_s;

    logic        ch_load_n = 1'b1;
    logic [11:0] ch_din = 12'h000;
    logic [3:0]  c0, c1, c2;
    logic        t0, t1, t2;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    presettable_counter #(.WIDTH(4), .CLEAR_SYNC(1'b0)) dut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din), .count(cnt_a), .term_cnt(tc_a));

    presettable_counter #(.WIDTH(4), .CLEAR_SYNC(1'b1)) dut_s (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din), .count(cnt_s), .term_cnt(tc_s));

    // Three-stage chain for R8
    presettable_counter #(.WIDTH(4), .CLEAR_SYNC(1'b0)) st0 (
        .clk(clk), .clear_n(clear_n), .load_n(ch_load_n), .cnt_en(1'b1),
        .chain_en(1'b1), .din(ch_din[3:0]), .count(c0), .term_cnt(t0));
    presettable_counter #(.WIDTH(4), .CLEAR_SYNC(1'b0)) st1 (
        .clk(clk), .clear_n(clear_n), .load_n(ch_load_n), .cnt_en(1'b1),
        .chain_en(t0), .din(ch_din[7:4]), .count(c1), .term_cnt(t1));
    presettable_counter #(.WIDTH(4), .CLEAR_SYNC(1'b0)) st2 (
        .clk(clk), .clear_n(clear_n), .load_n(ch_load_n), .cnt_en(1'b1),
        .chain_en(t1), .din(ch_din[11:8]), .count(c2), .term_cnt(t2));

    // Vector fields: load_n, cnt_en, chain_en, din, expected count, expected tc
    localparam int NVEC = 10;
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 1'b1, 4'hE, 4'hE, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'h0, 4'hF, 1'b1},
        {1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0},
        {1'b1, 1'b0, 1'b1, 4'h0, 4'h0, 1'b0},
        {1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1},
        {1'b1, 1'b0, 1'b1, 4'h0, 4'hF, 1'b1},
        {1'b1, 1'b1, 1'b0, 4'h0, 4'hF, 1'b0},
        {1'b0, 1'b1, 1'b1, 4'h5, 4'h5, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'h0, 4'h6, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'h0, 4'h7, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Reset state: clear with a pending load and count, both variants
        step();
        step();
        chk("R5 reset sync", 32'(cnt_s), 32'h0);
        chk("R6 reset async", 32'(cnt_a), 32'h0);
        chk("R7 tc at zero", 32'(tc_a), 32'h0);
        clear_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            {load_n, cnt_en, chain_en, din} = VEC[i][11:5];
            step();
            chk("R1-table async count", 32'(cnt_a), 32'(VEC[i][4:1]));
            chk("R2 R3 R4 table sync count", 32'(cnt_s), 32'(VEC[i][4:1]));
            chk("R7 table tc", 32'(tc_a), 32'(VEC[i][0]));
        end
        // Both stages now at 7 (wrap R1 at vector 3, load priority R4 at vector 8)

        // Mid-cycle clear: async acts at once, sync waits for the edge
        load_n = 1'b0; din = 4'h9; cnt_en = 1'b1; chain_en = 1'b1;
        clear_n = 1'b0;
        #1;
        chk("R6 async zero before edge", 32'(cnt_a), 32'h0);
        chk("R5 sync unchanged before edge", 32'(cnt_s), 32'h7);
        step();
        chk("R5 sync clear beats load", 32'(cnt_s), 32'h0);
        chk("R6 async stays zero", 32'(cnt_a), 32'h0);
        clear_n = 1'b1;

        // Terminal count follows chain_en within the cycle, ignores cnt_en
        load_n = 1'b0; din = 4'hF;
        step();
        load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b1;
        #1;
        chk("R7 tc high at 15", 32'(tc_a), 32'h1);
        chain_en = 1'b0;
        #1;
        chk("R7 tc drops with chain_en", 32'(tc_a), 32'h0);
        chk("R7 tc drops sync variant", 32'(tc_s), 32'h0);
        chain_en = 1'b1; cnt_en = 1'b1;
        #1;
        chk("R7 tc with cnt_en high", 32'(tc_a), 32'h1);
        cnt_en = 1'b0;
        #1;
        chk("R7 tc unaffected by cnt_en", 32'(tc_a), 32'h1);
        step();
        chk("R3 hold with cnt_en low", 32'(cnt_a), 32'hF);

        // Chained 12-bit rollover
        ch_din = 12'hFFD; ch_load_n = 1'b0;
        step();
        ch_load_n = 1'b1;
        chk("R8 chain loaded", 32'({c2, c1, c0}), 32'd4093);
        step();
        chk("R8 chain 4094", 32'({c2, c1, c0}), 32'd4094);
        step();
        chk("R8 chain 4095", 32'({c2, c1, c0}), 32'd4095);
        chk("R8 last stage tc", 32'(t2), 32'h1);
        step();
        chk("R8 chain wraps to 0", 32'({c2, c1, c0}), 32'd0);
        step();
        chk("R8 chain 1", 32'({c2, c1, c0}), 32'd1);

        finish_run();
    end
endmodule